// File: doc/BRIEF.md
# Two-Beat Floating-Point Request Pairing and Protocol Checker

This block sits on the request path from an on-chip crossbar to a floating-point unit. Every floating-point request crosses the interface as two beats. The first beat carries the opcode, the request ID and operand 1. The second beat carries operand 2. For a single-source operation, the second beat is still sent, but its valid bit is clear. The block pairs each first beat with the second beat that follows it, which may come after any number of idle cycles. It then presents one assembled request for one cycle.

While it pairs beats, the block checks the protocol. It looks for four faults: a packet out of order after a first beat, a valid second beat that claims a second source it must not have, a single-precision operand whose unused lower half is nonzero, and a second beat with no first beat before it. The first fault seen is latched on a sticky fault output with a 2-bit cause code. The fault output stays set until reset. Beats involved in a fault never produce an assembled request.

Top module: `fpreq_pair_check`

## Requirements
- R1: A packet takes part in pairing or checking only when `pkt_rdy` is high. The packet's valid bit (bit 123) marks it as a valid packet. A packet with `pkt_rdy` low is ignored. A packet whose valid bit is clear is ignored unless a first beat is pending.
- R2: Bits 122:118 hold the kind field: 0x0A is a first beat and 0x0B is a second beat. After a valid first beat, the next ready packet of kind 0x0B closes the pair. One cycle later `req_valid` pulses for exactly one cycle. With the pulse come the first beat's opcode (bits 79:72), its ID (bits 116:112) and its operand (bits 63:0) on `req_src1`, and the second beat's bits 63:0 on `req_src2`.
- R3: Any number of cycles with `pkt_rdy` low may separate the two beats of a pair without changing the result.
- R4: A second beat whose valid bit is clear closes a pending pair as a single-source request: `req_valid` pulses and `req_src2` is zero.
- R5: While a first beat is pending, a ready packet whose kind is not 0x0B is an ordering fault (cause 0) and the pending first beat is dropped.
- R6: A valid second beat with bit 79 set is a single-source fault (cause 1), and the pair is discarded with no pulse.
- R7: A valid first or second beat with bit 73 clear marks a single-precision operand. Its bits 31:0 must then be zero; otherwise it is a packing fault (cause 2). The faulty beat is discarded: a first beat is not held, and a second beat ends its pair with no pulse.
- R8: A valid second beat arriving with no first beat pending is an orphan fault (cause 3) and produces no pulse.
- R9: `fault` rises in the cycle after the first fault and then stays high. `fault_cause` keeps the cause of that first fault. When faults occur together, the lowest cause code is recorded.
- R10: Synchronous active-high reset clears the pending first beat, `req_valid`, `fault` and `fault_cause`.
- R11: A valid first beat that causes an ordering fault becomes the new pending first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pkt_rdy | input | 1 | Packet present strobe |
| pkt_word | input | 124 | Packet word |
| req_valid | output | 1 | One-cycle assembled-request pulse |
| req_opcode | output | 8 | Opcode held from the first beat |
| req_id | output | 5 | Request ID held from the first beat |
| req_src1 | output | 64 | Operand from the first beat |
| req_src2 | output | 64 | Operand from the second beat, zero for single source |
| fault | output | 1 | Sticky protocol fault flag |
| fault_cause | output | 2 | Code of the first fault recorded |

## Verification
The main hidden state is the pending-first-beat flag. When it is wrong, the error shows at the ports one cycle after the next second beat. A flag wrongly left clear raises an orphan fault (cause 3) and suppresses the pulse. A flag wrongly left set pulses with a stale opcode, or raises an ordering fault (cause 0) on the next first beat. Held opcode, ID or operand errors show only on the cycle of the pulse, so the bench compares every field there. It also uses reset-separated fault scenarios, so each cause code and the first-fault rule can be seen one cycle after the offending beat.

// File: rtl/fpreq_pkg.sv
package fpreq_pkg;
    localparam int PKT_W      = 124;
    localparam int OPND_W     = 64;
    localparam int OPC_W      = 8;
    localparam int ID_W       = 5;
    localparam int KIND_W     = 5;
    localparam int HALF_W     = OPND_W / 2;
    localparam int CAUSE_W    = 2;

    // Field positions decoded from the packet word
    localparam int VLD_BIT    = 123;
    localparam int KIND_LO    = 118;
    localparam int ID_LO      = 112;
    localparam int OPC_LO     = 72;
    localparam int SRC_SEL_BIT = 79;
    localparam int DBL_BIT    = 73;

    localparam logic [KIND_W-1:0] KIND_FIRST  = 5'h0A;
    localparam logic [KIND_W-1:0] KIND_SECOND = 5'h0B;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_ORDER      = 2'd0,
        CAUSE_SINGLE_SRC = 2'd1,
        CAUSE_SP_PACK    = 2'd2,
        CAUSE_ORPHAN     = 2'd3
    } cause_e;

    typedef struct packed {
        logic              present;   // strobe high
        logic              valid;     // strobe high and valid bit set
        logic              is_first;
        logic              is_second;
        logic              src_sel;   // second-source claim bit
        logic              sp_bad;    // single precision with nonzero lower half
        logic [OPC_W-1:0]  opc;
        logic [ID_W-1:0]   id;
        logic [OPND_W-1:0] opnd;
    } beat_t;

    typedef struct packed {
        logic order;
        logic single_src;
        logic sp_pack;
        logic orphan;
    } fault_vec_t;

    function automatic logic any_fault(input fault_vec_t f);
        return f.order | f.single_src | f.sp_pack | f.orphan;
    endfunction

    // Lowest code wins when several faults coincide
    function automatic cause_e pick_cause(input fault_vec_t f);
        if (f.order)           return CAUSE_ORDER;
        else if (f.single_src) return CAUSE_SINGLE_SRC;
        else if (f.sp_pack)    return CAUSE_SP_PACK;
        else                   return CAUSE_ORPHAN;
    endfunction
endpackage

// File: rtl/fpreq_beat_decode.sv
module fpreq_beat_decode
    import fpreq_pkg::*;
(
    input  logic             pkt_rdy,
    input  logic [PKT_W-1:0] pkt_word,
    output beat_t            beat
);
    logic [KIND_W-1:0] kind;
    logic              kind_known;

    always_comb begin
        kind       = pkt_word[KIND_LO +: KIND_W];
        kind_known = (kind == KIND_FIRST) || (kind == KIND_SECOND);

        beat.present   = pkt_rdy;
        beat.valid     = pkt_rdy & pkt_word[VLD_BIT];
        beat.is_first  = (kind == KIND_FIRST);
        beat.is_second = (kind == KIND_SECOND);
        beat.src_sel   = pkt_word[SRC_SEL_BIT];
        beat.opc       = pkt_word[OPC_LO +: OPC_W];
        beat.id        = pkt_word[ID_LO +: ID_W];
        beat.opnd      = pkt_word[OPND_W-1:0];
        beat.sp_bad    = beat.valid & kind_known & ~pkt_word[DBL_BIT]
                       & (|pkt_word[HALF_W-1:0]);
    end
endmodule

// File: rtl/fpreq_pair_tracker.sv
module fpreq_pair_tracker
    import fpreq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  beat_t             beat,
    output fault_vec_t        faults,
    output logic              req_valid,
    output logic [OPC_W-1:0]  req_opcode,
    output logic [ID_W-1:0]   req_id,
    output logic [OPND_W-1:0] req_src1,
    output logic [OPND_W-1:0] req_src2
);
    logic              pending;
    logic [OPC_W-1:0]  held_opc;
    logic [ID_W-1:0]   held_id;
    logic [OPND_W-1:0] held_opnd;

    logic close_pair;
    logic take_first;
    logic emit;

    always_comb begin
        close_pair        = pending & beat.present & beat.is_second;
        take_first        = beat.valid & beat.is_first & ~beat.sp_bad;

        faults.order      = pending & beat.present & ~beat.is_second;
        faults.single_src = close_pair & beat.valid & beat.src_sel;
        faults.sp_pack    = beat.sp_bad;
        faults.orphan     = ~pending & beat.valid & beat.is_second;

        emit = close_pair & ~faults.single_src & ~beat.sp_bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending   <= 1'b0;
            held_opc  <= '0;
            held_id   <= '0;
            held_opnd <= '0;
            req_valid <= 1'b0;
            req_opcode <= '0;
            req_id    <= '0;
            req_src1  <= '0;
            req_src2  <= '0;
        end else begin
            if (take_first) begin
                pending   <= 1'b1;
                held_opc  <= beat.opc;
                held_id   <= beat.id;
                held_opnd <= beat.opnd;
            end else if (close_pair || faults.order) begin
                pending   <= 1'b0;
            end

            req_valid <= emit;
            if (emit) begin
                req_opcode <= held_opc;
                req_id     <= held_id;
                req_src1   <= held_opnd;
                req_src2   <= beat.valid ? beat.opnd : '0;
            end
        end
    end

    // R2: a pulse needs a pair that was open one cycle earlier
    assert_pulse_has_pair_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $past(pending));

    // R2: pulses never come back to back
    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid);

    // R8: an orphan second beat never yields a request
    assert_orphan_no_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        faults.orphan |=> !req_valid);

    // R5: an ordering fault never yields a request
    assert_order_no_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        faults.order |=> !req_valid);
endmodule

// File: rtl/fpreq_fault_latch.sv
module fpreq_fault_latch
    import fpreq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  fault_vec_t         faults,
    output logic               fault,
    output logic [CAUSE_W-1:0] fault_cause
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fault       <= 1'b0;
            fault_cause <= '0;
        end else if (!fault && any_fault(faults)) begin
            fault       <= 1'b1;
            fault_cause <= pick_cause(faults);
        end
    end

    // R9: the flag holds once raised
    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    // R9: the recorded cause never changes while the flag is up
    assert_cause_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        fault |=> $stable(fault_cause));

    // R9: the flag only rises after a detected fault
    assert_fault_has_source_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> $past(any_fault(faults)));
endmodule

// File: rtl/fpreq_pair_check.sv
module fpreq_pair_check
    import fpreq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               pkt_rdy,
    input  logic [PKT_W-1:0]   pkt_word,
    output logic               req_valid,
    output logic [OPC_W-1:0]   req_opcode,
    output logic [ID_W-1:0]    req_id,
    output logic [OPND_W-1:0]  req_src1,
    output logic [OPND_W-1:0]  req_src2,
    output logic               fault,
    output logic [CAUSE_W-1:0] fault_cause
);
    beat_t      beat;
    fault_vec_t faults;

    fpreq_beat_decode u_decode (
        .pkt_rdy  (pkt_rdy),
        .pkt_word (pkt_word),
        .beat     (beat)
    );

    fpreq_pair_tracker u_tracker (
        .clk        (clk),
        .rst        (rst),
        .beat       (beat),
        .faults     (faults),
        .req_valid  (req_valid),
        .req_opcode (req_opcode),
        .req_id     (req_id),
        .req_src1   (req_src1),
        .req_src2   (req_src2)
    );

    fpreq_fault_latch u_faults (
        .clk         (clk),
        .rst         (rst),
        .faults      (faults),
        .fault       (fault),
        .fault_cause (fault_cause)
    );

    // R10: reset leaves no pulse and no fault behind
    assert_reset_clean_R10: assert property (@(posedge clk)
        rst |=> (!req_valid && !fault));
endmodule

// File: tb/fpreq_pair_check_tb.sv
module fpreq_pair_check_tb;
    import fpreq_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               pkt_rdy = 1'b0;
    logic [PKT_W-1:0]   pkt_word = '0;
    logic               req_valid;
    logic [OPC_W-1:0]   req_opcode;
    logic [ID_W-1:0]    req_id;
    logic [OPND_W-1:0]  req_src1;
    logic [OPND_W-1:0]  req_src2;
    logic               fault;
    logic [CAUSE_W-1:0] fault_cause;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    fpreq_pair_check u_dut (
        .clk(clk), .rst(rst), .pkt_rdy(pkt_rdy), .pkt_word(pkt_word),
        .req_valid(req_valid), .req_opcode(req_opcode), .req_id(req_id),
        .req_src1(req_src1), .req_src2(req_src2),
        .fault(fault), .fault_cause(fault_cause)
    );

    // Kind codes: 0x0A first beat, 0x0B second beat, others unrelated
    localparam logic [4:0] KA = 5'h0A;
    localparam logic [4:0] KB = 5'h0B;
    localparam logic [4:0] KX = 5'h04;
    localparam logic [63:0] SP_OK  = 64'h3F80_0000_0000_0000;
    localparam logic [63:0] SP_BAD = 64'h3F80_0000_0000_0001;

    function automatic logic [PKT_W-1:0] mk(input logic v, input logic [4:0] kind,
                                             input logic [7:0] opc, input logic [4:0] id,
                                             input logic [63:0] data);
        logic [PKT_W-1:0] w;
        w = '0;
        w[123]     = v;
        w[122:118] = kind;
        w[116:112] = id;
        w[79:72]   = opc;
        w[63:0]    = data;
        return w;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one cycle of input; outputs reflecting it are valid on return
    task automatic beat(input logic rdy, input logic v, input logic [4:0] kind,
                        input logic [7:0] opc, input logic [4:0] id, input logic [63:0] data);
        pkt_rdy  = rdy;
        pkt_word = mk(v, kind, opc, id, data);
        @(negedge clk);
    endtask

    task automatic idle();
        beat(1'b0, 1'b0, 5'h0, 8'h0, 5'h0, 64'h0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        pkt_rdy = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    typedef struct packed {
        logic        rdy;
        logic        v;
        logic [4:0]  kind;
        logic [7:0]  opc;
        logic [63:0] data;
        logic        exp_valid;
    } vec_t;

    // opc bit 1 maps to packet bit 73 (double precision), opc bit 7 to bit 79
    localparam vec_t TBL [10] = '{
        '{1'b1, 1'b1, KA, 8'h41, SP_OK,                 1'b0}, // R2 first beat, single precision
        '{1'b0, 1'b0, KB, 8'h00, 64'h0,                 1'b0}, // R3 stall
        '{1'b0, 1'b1, KA, 8'h00, 64'h0,                 1'b0}, // R3 stall, R1 strobe low
        '{1'b1, 1'b0, KB, 8'h00, 64'hFFFF,              1'b1}, // R4 invalid second beat
        '{1'b1, 1'b1, KA, 8'h42, 64'h4000_0000_0000_0001, 1'b0}, // R2 double precision
        '{1'b1, 1'b1, KB, 8'h02, 64'h1234,              1'b1}, // R2 close
        '{1'b0, 1'b1, KB, 8'h02, 64'h5,                 1'b0}, // R1 strobe low ignored
        '{1'b1, 1'b0, KX, 8'h00, 64'h7,                 1'b0}, // R1 invalid ignored
        '{1'b1, 1'b1, KA, 8'h43, 64'h99,                1'b0}, // R2
        '{1'b1, 1'b1, KB, 8'h06, 64'h88,                1'b1}  // R2
    };

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R10 reset state
        chk("R10 reset req_valid", req_valid, 0);
        chk("R10 reset fault", fault, 0);

        for (int i = 0; i < 10; i++) begin
            beat(TBL[i].rdy, TBL[i].v, TBL[i].kind, TBL[i].opc, 5'd1, TBL[i].data);
            chk($sformatf("R1/R2/R3/R4 table row %0d req_valid", i), req_valid, TBL[i].exp_valid);
            chk($sformatf("R1 table row %0d no fault", i), fault, 0);
        end

        // R2 field transfer
        do_reset();
        beat(1, 1, KA, 8'h46, 5'd7, 64'hDEAD_BEEF_0123_4567);
        idle();
        beat(1, 1, KB, 8'h02, 5'd2, 64'hCAFE_0000_1111_2222);
        chk("R2 pulse", req_valid, 1);
        chk("R2 opcode", req_opcode, 8'h46);
        chk("R2 id", req_id, 5'd7);
        chk("R2 src1", req_src1, 64'hDEAD_BEEF_0123_4567);
        chk("R2 src2", req_src2, 64'hCAFE_0000_1111_2222);
        idle();
        chk("R2 pulse ends", req_valid, 0);

        // R4 single-source closes with zero second operand
        beat(1, 1, KA, 8'h44, 5'd3, SP_OK);
        beat(1, 0, KB, 8'h00, 5'd0, 64'h55);
        chk("R4 pulse", req_valid, 1);
        chk("R4 src2 zero", req_src2, 64'h0);
        chk("R4 no fault", fault, 0);

        // R5 ordering fault, then R9 sticky cause
        do_reset();
        beat(1, 1, KA, 8'h42, 5'd1, 64'h1);
        beat(1, 1, KX, 8'h42, 5'd1, 64'h1);
        chk("R5 fault", fault, 1);
        chk("R5 cause", fault_cause, 0);
        chk("R5 no pulse", req_valid, 0);
        beat(1, 1, KB, 8'h02, 5'd1, 64'h2);
        chk("R5 pair dropped", req_valid, 0);
        chk("R9 cause kept", fault_cause, 0);

        // R11 new first beat replaces the dropped one
        do_reset();
        beat(1, 1, KA, 8'h42, 5'd1, 64'h10);
        beat(1, 1, KA, 8'h4E, 5'd9, 64'h20);
        chk("R11 order fault", fault, 1);
        beat(1, 1, KB, 8'h02, 5'd1, 64'h30);
        chk("R11 pulse", req_valid, 1);
        chk("R11 opcode", req_opcode, 8'h4E);
        chk("R11 src1", req_src1, 64'h20);

        // R6 single-source fault
        do_reset();
        beat(1, 1, KA, 8'h42, 5'd1, 64'h1);
        beat(1, 1, KB, 8'h82, 5'd1, 64'h2);
        chk("R6 fault", fault, 1);
        chk("R6 cause", fault_cause, 1);
        chk("R6 no pulse", req_valid, 0);

        // R7 packing fault on first beat; beat discarded
        do_reset();
        beat(1, 1, KA, 8'h40, 5'd1, SP_BAD);
        chk("R7 fault", fault, 1);
        chk("R7 cause", fault_cause, 2);
        beat(1, 1, KB, 8'h02, 5'd1, 64'h2);
        chk("R7 first discarded", req_valid, 0);
        chk("R9 cause kept after orphan", fault_cause, 2);

        // R7 packing fault on second beat
        do_reset();
        beat(1, 1, KA, 8'h42, 5'd1, 64'h1);
        beat(1, 1, KB, 8'h00, 5'd1, SP_BAD);
        chk("R7 second no pulse", req_valid, 0);
        chk("R7 second cause", fault_cause, 2);

        // R8 orphan
        do_reset();
        beat(1, 1, KB, 8'h02, 5'd1, 64'h2);
        chk("R8 fault", fault, 1);
        chk("R8 cause", fault_cause, 3);
        chk("R8 no pulse", req_valid, 0);

        // R9 priority: single-source and packing together
        do_reset();
        beat(1, 1, KA, 8'h42, 5'd1, 64'h1);
        beat(1, 1, KB, 8'h80, 5'd1, SP_BAD);
        chk("R9 priority cause", fault_cause, 1);

        // R10 reset drops a pending first beat
        do_reset();
        beat(1, 1, KA, 8'h42, 5'd1, 64'h1);
        do_reset();
        chk("R10 fault cleared", fault, 0);
        beat(1, 1, KB, 8'h02, 5'd1, 64'h2);
        chk("R10 pending cleared", fault_cause, 3);
        chk("R10 no pulse", req_valid, 0);

        // R1 strobe-low first beat ignored
        do_reset();
        beat(0, 1, KA, 8'h42, 5'd1, 64'h1);
        beat(1, 1, KB, 8'h02, 5'd1, 64'h2);
        chk("R1 ignored first beat", fault_cause, 3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule